// File: doc/BRIEF.md
# Dual Page-Size TLB Address Translator

This block turns a virtual address into a physical address by searching two translation buffers at once. Each buffer holds sixteen entries as eight sets of two ways, and each has its own page size of 1 KB, 2 KB, 4 KB or 8 KB, chosen by a two-bit input. With equal sizes the pair acts as one larger cache of translations. With different sizes one buffer can map code in small pages and the other can map data in large pages.

A request carries a virtual address, the current process identifier and a valid strobe. The block registers the request and reports one cycle later. It reports either a hit with the physical address, or a one-cycle miss flag that tells software to load an entry. Software loads entries through a write port that names the buffer, set and way. A single flush input clears every entry in both buffers.

Top module: `dtlb_translator`

## Requirements
- R1: After reset, `rsp_hit` and `rsp_miss` are low, and every entry of both buffers is invalid, so the first lookup misses.
- R2: A request accepted on a rising edge gives exactly one of `rsp_hit` or `rsp_miss` for the following cycle only. With no request, both flags stay low.
- R3: Page-size code k (0..3) gives an offset of 10+k bits. The set index is the 3 virtual-address bits directly above that offset, so the index position moves with the page size.
- R4: The stored tag is the virtual address shifted right by offset+3, zero-extended to the tag width. An entry whose tag differs does not hit.
- R5: An entry with its global bit clear hits only when its stored process identifier equals `req_pid`.
- R6: An entry with its global bit set hits under any process identifier.
- R7: On a hit, `rsp_paddr` is the entry's physical page number shifted left by the offset, ORed with the offset bits of the virtual address, truncated to the physical width.
- R8: If both buffers hit, the translation comes from buffer 0 (`wr_sel`=0).
- R9: Each buffer uses its own page-size input (`pg_size_a` for buffer 0, `pg_size_b` for buffer 1) to form its index, tag and address.
- R10: An entry written with its valid bit low never hits.
- R11: `flush` clears every valid bit in both buffers in one cycle. It wins over a write on the same edge, and a request taken on that edge misses.
- R12: A write on an edge is seen by a request taken on the same edge.
- R13: The two ways of a set are written and matched independently, and `wr_way` selects which way a write replaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_pid | input | 8 | Current process identifier |
| pg_size_a | input | 2 | Page-size code for buffer 0 |
| pg_size_b | input | 2 | Page-size code for buffer 1 |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 1 | Target buffer of the write |
| wr_set | input | 3 | Target set |
| wr_way | input | 1 | Target way |
| wr_tag | input | 19 | Tag to store |
| wr_pid | input | 8 | Process identifier to store |
| wr_global | input | 1 | Global-page bit to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_ppn | input | 22 | Physical page number to store |
| flush | input | 1 | Invalidate all entries of both buffers |
| rsp_hit | output | 1 | Translation found (one cycle after request) |
| rsp_miss | output | 1 | Translation not found (one cycle after request) |
| rsp_paddr | output | 32 | Physical address, zero when not a hit |

## Verification
The bench moves the page sizes between 1 KB, 4 KB and 8 KB. A design that took the index from fixed bits would then put entries in the wrong set and miss, or join the offset at the wrong bit and give a bad address. It places one address in both buffers with different page numbers. A design with the priority reversed would return buffer 1's page. It probes the process-identifier check with and without the global bit, and it stores an entry with the valid bit low. It also lines up a write and a flush with a request on the same edge. A design that let the write beat the flush, or that delayed writes by a cycle, would report a hit where a miss is due, or a miss where a hit is due.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int PID_W   = 8;
    localparam int MIN_OFF = 10;
    localparam int SETS    = 8;
    localparam int WAYS    = 2;
    localparam int NUM_TLB = 2;
    localparam int PGSZ_W  = 2;

    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TSEL_W = (NUM_TLB > 1) ? $clog2(NUM_TLB) : 1;
    localparam int TAG_W  = VA_W - MIN_OFF - IDX_W;
    localparam int PPN_W  = PA_W - MIN_OFF;

    typedef logic [VA_W-1:0]   vaddr_t;
    typedef logic [PA_W-1:0]   paddr_t;
    typedef logic [PID_W-1:0]  pid_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [PPN_W-1:0]  ppn_t;
    typedef logic [IDX_W-1:0]  set_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [PGSZ_W-1:0] pgsz_t;

    typedef enum logic [PGSZ_W-1:0] {
        PG_1K = 2'd0,
        PG_2K = 2'd1,
        PG_4K = 2'd2,
        PG_8K = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic valid;
        logic global;
        pid_t pid;
        tag_t tag;
        ppn_t ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic                     valid;
        vaddr_t                   va;
        pid_t                     pid;
        logic [NUM_TLB-1:0][PGSZ_W-1:0] pg;
    } lookup_req_t;

    // Number of page-offset bits for a page-size code.
    function automatic int unsigned off_bits(input pgsz_t pg);
        return MIN_OFF + int'(pg);
    endfunction

    function automatic set_t set_of(input vaddr_t va, input pgsz_t pg);
        return set_t'(va >> off_bits(pg));
    endfunction

    function automatic tag_t tag_of(input vaddr_t va, input pgsz_t pg);
        return tag_t'(va >> (off_bits(pg) + IDX_W));
    endfunction

    // Physical page number placed above the offset bits of the virtual address.
    function automatic paddr_t join_pa(input ppn_t ppn, input vaddr_t va, input pgsz_t pg);
        paddr_t hi;
        paddr_t mask;
        hi   = paddr_t'(ppn) << off_bits(pg);
        mask = (paddr_t'(1) << off_bits(pg)) - paddr_t'(1);
        return hi | (paddr_t'(va) & mask);
    endfunction

endpackage

// File: rtl/dtlb_req_stage.sv
module dtlb_req_stage
    import dtlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  vaddr_t      in_va,
    input  pid_t        in_pid,
    input  logic [NUM_TLB-1:0][PGSZ_W-1:0] in_pg,
    output lookup_req_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= in_valid;
            if (in_valid) begin
                q.va  <= in_va;
                q.pid <= in_pid;
                q.pg  <= in_pg;
            end
        end
    end

endmodule

// File: rtl/dtlb_bank.sv
module dtlb_bank
    import dtlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       wr_en,
    input  set_t       wr_set,
    input  way_t       wr_way,
    input  tlb_entry_t wr_entry,
    input  vaddr_t     lk_va,
    input  pid_t       lk_pid,
    input  pgsz_t      lk_pg,
    output logic       lk_hit,
    output paddr_t     lk_pa
);

    tlb_entry_t mem [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    mem[s][w].valid <= 1'b0;
                end
            end
        end else if (wr_en) begin
            mem[wr_set][wr_way] <= wr_entry;
        end
    end

    set_t lk_set;
    tag_t lk_tag;
    logic [WAYS-1:0] way_match;
    ppn_t way_ppn [WAYS];

    assign lk_set = set_of(lk_va, lk_pg);
    assign lk_tag = tag_of(lk_va, lk_pg);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_entry_t ent;
        assign ent = mem[lk_set][w];
        assign way_match[w] = ent.valid
                           && (ent.tag == lk_tag)
                           && (ent.global || (ent.pid == lk_pid));
        assign way_ppn[w] = ent.ppn;
    end

    ppn_t sel_ppn;
    always_comb begin
        sel_ppn = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) sel_ppn = way_ppn[w];
        end
    end

    assign lk_hit = |way_match;
    assign lk_pa  = join_pa(sel_ppn, lk_va, lk_pg);

endmodule

// File: rtl/dtlb_merge.sv
module dtlb_merge
    import dtlb_pkg::*;
(
    input  logic [NUM_TLB-1:0] bank_hit,
    input  paddr_t             bank_pa [NUM_TLB],
    output logic               any_hit,
    output paddr_t             sel_pa
);

    // Lowest-numbered buffer wins when several hit.
    always_comb begin
        sel_pa = '0;
        for (int b = NUM_TLB - 1; b >= 0; b--) begin
            if (bank_hit[b]) sel_pa = bank_pa[b];
        end
    end

    assign any_hit = |bank_hit;

endmodule

// File: rtl/dtlb_translator.sv
module dtlb_translator
    import dtlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [7:0]  req_pid,
    input  logic [1:0]  pg_size_a,
    input  logic [1:0]  pg_size_b,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [2:0]  wr_set,
    input  logic        wr_way,
    input  logic [18:0] wr_tag,
    input  logic [7:0]  wr_pid,
    input  logic        wr_global,
    input  logic        wr_valid,
    input  logic [21:0] wr_ppn,
    input  logic        flush,
    output logic        rsp_hit,
    output logic        rsp_miss,
    output logic [31:0] rsp_paddr
);

    lookup_req_t req_q;
    logic [NUM_TLB-1:0][PGSZ_W-1:0] pg_in;
    tlb_entry_t wr_entry;

    assign pg_in = {pg_size_b, pg_size_a};

    assign wr_entry = '{
        valid:  wr_valid,
        global: wr_global,
        pid:    wr_pid,
        tag:    wr_tag,
        ppn:    wr_ppn
    };

    dtlb_req_stage u_req (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_va    (req_vaddr),
        .in_pid   (req_pid),
        .in_pg    (pg_in),
        .q        (req_q)
    );

    logic [NUM_TLB-1:0] bank_hit;
    paddr_t             bank_pa [NUM_TLB];

    for (genvar b = 0; b < NUM_TLB; b++) begin : g_bank
        dtlb_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .wr_en    (wr_en && (wr_sel == TSEL_W'(b))),
            .wr_set   (wr_set),
            .wr_way   (wr_way),
            .wr_entry (wr_entry),
            .lk_va    (req_q.va),
            .lk_pid   (req_q.pid),
            .lk_pg    (req_q.pg[b]),
            .lk_hit   (bank_hit[b]),
            .lk_pa    (bank_pa[b])
        );
    end

    logic   any_hit;
    paddr_t sel_pa;

    dtlb_merge u_merge (
        .bank_hit (bank_hit),
        .bank_pa  (bank_pa),
        .any_hit  (any_hit),
        .sel_pa   (sel_pa)
    );

    assign rsp_hit   = req_q.valid && any_hit;
    assign rsp_miss  = req_q.valid && !any_hit;
    assign rsp_paddr = rsp_hit ? sel_pa : '0;

endmodule

// File: rtl/dtlb_translator_chk.sv
module dtlb_translator_chk
    import dtlb_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   req_valid,
    input vaddr_t req_vaddr,
    input logic   flush,
    input logic   rsp_hit,
    input logic   rsp_miss,
    input paddr_t rsp_paddr
);

    // R1: quiet outputs in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_hit && !rsp_miss));

    // R2: one response flag per accepted request
    p_one_resp_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_hit ^ rsp_miss));

    // R2: no flag without a request
    p_no_resp_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_hit && !rsp_miss));

    // R7: offset bits pass straight through on a hit
    p_offset_pass_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr[MIN_OFF-1:0] == $past(req_vaddr[MIN_OFF-1:0])));

    // R11: a request taken with a flush misses
    p_flush_miss_r11: assert property (@(posedge clk) disable iff (rst)
        (flush && req_valid) |=> rsp_miss);

endmodule

bind dtlb_translator dtlb_translator_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .flush     (flush),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_paddr (rsp_paddr)
);

// File: tb/dtlb_translator_tb.sv
`timescale 1ns/1ps
module dtlb_translator_tb;
    import dtlb_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    vaddr_t      req_vaddr = '0;
    pid_t        req_pid = '0;
    logic [1:0]  pga = 2'd0, pgb = 2'd0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, wr_way = 1'b0;
    set_t        wr_set = '0;
    tag_t        wr_tag = '0;
    pid_t        wr_pid = '0;
    logic        wr_global = 1'b0, wr_valid = 1'b0;
    ppn_t        wr_ppn = '0;
    logic        flush = 1'b0;
    logic        rsp_hit, rsp_miss;
    paddr_t      rsp_paddr;

    dtlb_translator u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_pid(req_pid), .pg_size_a(pga), .pg_size_b(pgb),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_set(wr_set), .wr_way(wr_way),
        .wr_tag(wr_tag), .wr_pid(wr_pid), .wr_global(wr_global),
        .wr_valid(wr_valid), .wr_ppn(wr_ppn), .flush(flush),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Shadow of the buffer contents, kept from the requirements.
    bit   m_v   [2][SETS][WAYS];
    bit   m_g   [2][SETS][WAYS];
    pid_t m_pid [2][SETS][WAYS];
    tag_t m_tag [2][SETS][WAYS];
    ppn_t m_ppn [2][SETS][WAYS];

    bit     eh_q [$];
    paddr_t ep_q [$];
    string  tag_q [$];

    task automatic check(input bit ok, input string r, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic int page_off(input int t);
        return 10 + ((t == 0) ? int'(pga) : int'(pgb));
    endfunction

    function automatic void model(input vaddr_t va, input pid_t pid,
                                  output bit h, output paddr_t pa);
        h = 1'b0;
        pa = '0;
        for (int t = 0; t < 2; t++) begin
            int   off;
            int   s;
            tag_t tg;
            off = page_off(t);
            s   = int'((va >> off) & 32'h7);
            tg  = tag_t'(va >> (off + 3));
            for (int w = 0; w < WAYS; w++) begin
                if (!h && m_v[t][s][w] && m_tag[t][s][w] == tg
                    && (m_g[t][s][w] || m_pid[t][s][w] == pid)) begin
                    h  = 1'b1;
                    pa = (paddr_t'(m_ppn[t][s][w]) << off)
                       | (paddr_t'(va) & ((paddr_t'(1) << off) - paddr_t'(1)));
                end
            end
        end
    endfunction

    task automatic push(input vaddr_t va, input pid_t pid, input string r);
        bit     h;
        paddr_t pa;
        model(va, pid, h, pa);
        eh_q.push_back(h);
        ep_q.push_back(pa);
        tag_q.push_back(r);
    endtask

    task automatic lookup(input vaddr_t va, input pid_t pid, input string r);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_pid   = pid;
        @(posedge clk);
        #1;
        push(va, pid, r);
        req_valid = 1'b0;
    endtask

    task automatic wr(input int t, input vaddr_t va, input int way, input pid_t pid,
                      input bit g, input bit v, input ppn_t ppn,
                      input bit with_req, input vaddr_t rva, input pid_t rpid,
                      input string r);
        int off;
        int s;
        off = page_off(t);
        s   = int'((va >> off) & 32'h7);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_sel    = t[0];
        wr_set    = set_t'(s);
        wr_way    = way[0];
        wr_tag    = tag_t'(va >> (off + 3));
        wr_pid    = pid;
        wr_global = g;
        wr_valid  = v;
        wr_ppn    = ppn;
        if (with_req) begin
            req_valid = 1'b1;
            req_vaddr = rva;
            req_pid   = rpid;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        m_v[t][s][way]   = v;
        m_g[t][s][way]   = g;
        m_pid[t][s][way] = pid;
        m_tag[t][s][way] = tag_t'(va >> (off + 3));
        m_ppn[t][s][way] = ppn;
        if (with_req) begin
            push(rva, rpid, r);
            req_valid = 1'b0;
        end
    endtask

    // Flush together with a write into buffer 0 and a request, all on one edge.
    task automatic flush_all(input vaddr_t rva, input pid_t rpid);
        @(negedge clk);
        flush     = 1'b1;
        wr_en     = 1'b1;
        wr_sel    = 1'b0;
        wr_set    = set_t'((rva >> page_off(0)) & 32'h7);
        wr_way    = 1'b0;
        wr_tag    = tag_t'(rva >> (page_off(0) + 3));
        wr_pid    = rpid;
        wr_global = 1'b1;
        wr_valid  = 1'b1;
        wr_ppn    = 22'h155;
        req_valid = 1'b1;
        req_vaddr = rva;
        req_pid   = rpid;
        @(posedge clk);
        #1;
        flush = 1'b0;
        wr_en = 1'b0;
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    m_v[t][s][w] = 1'b0;
        push(rva, rpid, "R11");
        req_valid = 1'b0;
    endtask

    // Monitor: one expected item per response cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (eh_q.size() > 0) begin
                bit     eh;
                paddr_t ep;
                string  r;
                eh = eh_q.pop_front();
                ep = ep_q.pop_front();
                r  = tag_q.pop_front();
                check(rsp_hit == eh, r, "hit", 64'(rsp_hit), 64'(eh));
                check(rsp_miss == !eh, r, "miss", 64'(rsp_miss), 64'(!eh));
                if (eh) check(rsp_paddr == ep, r, "paddr", 64'(rsp_paddr), 64'(ep));
            end else if (rsp_hit || rsp_miss) begin
                check(1'b0, "R2", "idle flags", 64'({rsp_hit, rsp_miss}), 64'd0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    localparam vaddr_t VA_A = 32'h0001_2345;
    localparam vaddr_t VA_B = 32'h0040_7ABC;
    localparam vaddr_t VA_C = 32'h00AB_CDEF;

    initial begin
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    m_v[t][s][w] = 1'b0; m_g[t][s][w] = 1'b0;
                    m_pid[t][s][w] = '0; m_tag[t][s][w] = '0; m_ppn[t][s][w] = '0;
                end
        pga = PG_1K;
        pgb = PG_4K;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check(rsp_hit == 1'b0, "R1", "hit after reset", 64'(rsp_hit), 64'd0);
        check(rsp_miss == 1'b0, "R1", "miss after reset", 64'(rsp_miss), 64'd0);
        lookup(VA_A, 8'd5, "R1");

        // R3 R4 R5 R7: private entry in buffer 0, 1 KB pages
        wr(0, VA_A, 0, 8'd5, 1'b0, 1'b1, 22'h2A5A5, 1'b0, '0, '0, "");
        lookup(VA_A, 8'd5, "R7");
        lookup(VA_A, 8'd6, "R5");
        lookup(VA_A ^ 32'h0000_2000, 8'd5, "R4");
        lookup(VA_A ^ 32'h0000_0400, 8'd5, "R3");

        // R6 R13: global entry in the other way of the same set
        wr(0, VA_A ^ 32'h0100_0000, 1, 8'd7, 1'b1, 1'b1, 22'h00123, 1'b0, '0, '0, "");
        lookup(VA_A ^ 32'h0100_0000, 8'd99, "R6");
        lookup(VA_A, 8'd5, "R13");

        // R9: buffer 1 with 4 KB pages
        wr(1, VA_B, 0, 8'd3, 1'b0, 1'b1, 22'h0BEEF, 1'b0, '0, '0, "");
        lookup(VA_B, 8'd3, "R9");
        lookup(VA_B + 32'h0000_0F00, 8'd3, "R9");

        // R8: same address mapped in both buffers
        wr(1, VA_A, 1, 8'd5, 1'b0, 1'b1, 22'h3FFFF, 1'b0, '0, '0, "");
        lookup(VA_A, 8'd5, "R8");

        // R10: entry written invalid
        wr(0, VA_C, 1, 8'd1, 1'b1, 1'b0, 22'h00777, 1'b0, '0, '0, "");
        lookup(VA_C, 8'd1, "R10");

        // R3: 8 KB pages move the index and the offset join
        @(negedge clk);
        pga = PG_8K;
        wr(0, VA_C, 0, 8'd1, 1'b0, 1'b1, 22'h01234, 1'b0, '0, '0, "");
        lookup(VA_C, 8'd1, "R3");
        lookup(VA_C ^ 32'h0000_1000, 8'd1, "R3");

        // R12: write and request on the same edge
        wr(1, VA_C, 0, 8'd2, 1'b0, 1'b1, 22'h0CAFE, 1'b1, VA_C, 8'd2, "R12");

        // R2: back-to-back requests
        lookup(VA_B, 8'd3, "R2");
        lookup(VA_C, 8'd1, "R2");
        lookup(VA_A, 8'd9, "R2");

        // R11: flush wins over a write and makes everything miss
        flush_all(VA_B, 8'd3);
        lookup(VA_B, 8'd3, "R11");
        lookup(VA_C, 8'd1, "R11");
        lookup(VA_A, 8'd5, "R11");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule